// File: doc/BRIEF.md
# Programmable Sample-Rate Strobe Generator

This block derives a sample-enable pulse train from a fast reference clock. Software sets the rate through a byte-wide register write port with three fields: a selection code that picks a base rate from a fixed table of decade and half-step values, an 8-bit multiplier, and an 8-bit divisor. The requested rate is base times multiplier over divisor. A phase accumulator realises that fraction with no long-run drift. Each reference cycle it adds the increment base × multiplier. When the sum reaches divisor × reference rate, it emits a one-cycle strobe and keeps the remainder.

A selection code outside the table, or a divisor of zero, raises an unsupported-setting flag and silences the strobe. Any write to a rate field clears the accumulator, so the pulse train restarts cleanly under the new setting and never mixes old and new fractions. One further offset holds a constant register that is written during configuration; the block accepts that write and ignores it. Rates are counted internally in half-hertz units, so that the slowest table entry is an integer.

Top module: `sample_rate_gen`

## Requirements
- R1: Reset (synchronous, active high) loads selection code 16, multiplier 5 and divisor 5, which is 1 MHz. While reset is held and on the first cycle after it, both outputs are low. Counting starts with an empty accumulator.
- R2: Selection codes map to base rates as follows. 0, 1 and 2 select 10 MHz, 5 MHz and 2.5 MHz. 16 and 17 select 1 MHz and 500 kHz. 32 and 33 select 100 kHz and 50 kHz. 48, 49 and 50 select 10 kHz, 5 kHz and 2.5 kHz. 64 to 68 select 1 kHz, 500 Hz, 250 Hz, 125 Hz and 62.5 Hz.
- R3: On a valid setting with no write, the strobe count over the N cycles after the accumulator starts from zero equals floor(N × base × multiplier / (divisor × REF_HZ)).
- R4: A write with wr_en high is decoded by wr_addr. 0x30 loads the divisor, 0x31 loads the multiplier and 0x34 loads the selection code. Writes to 0x32 (the constant register) and to any other address change no setting, do not clear the accumulator, and leave the strobe train undisturbed.
- R5: A write to 0x30, 0x31 or 0x34 clears the accumulator, and no strobe follows that edge. With a ratio of 1/k, the next strobe follows the k-th edge after it.
- R6: A divisor of zero raises unsup_o and keeps strobe_o low. unsup_o reflects the setting present before each edge, so it is valid from the second edge after the write.
- R7: A selection code not listed in R2 raises unsup_o and keeps strobe_o low. Rewriting a valid setting lowers the flag again.
- R8: When base × multiplier / divisor is at least REF_HZ, strobe_o is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write offset |
| wr_data | input | REG_W | Register write data |
| strobe_o | output | 1 | Registered one-cycle sample enable |
| unsup_o | output | 1 | Registered unsupported-setting flag |

## Verification
A write is captured on one edge, which clears the accumulator. Strobes under the new setting can first appear after the next edge, and the flag is valid after that same next edge. The bench drives inputs on falling edges and samples on falling edges. Its window counter begins at the first falling edge after the capturing edge, so cycle j of a window is the value after the j-th edge. Writes injected inside a window are placed at a known cycle, and the expected counts are computed for exactly that alignment.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int SR_ADDR_DIV   = 'h30;
  localparam int SR_ADDR_MUL   = 'h31;
  localparam int SR_ADDR_CONST = 'h32;
  localparam int SR_ADDR_CODE  = 'h34;

  localparam int SR_DEF_DIV  = 5;
  localparam int SR_DEF_MUL  = 5;
  localparam int SR_DEF_CODE = 16;

  localparam int SR_NUM_GROUPS = 5;

  // highest valid step index inside each decade group
  function automatic int sr_group_limit(input int grp);
    case (grp)
      0: return 2;
      1: return 1;
      2: return 1;
      3: return 2;
      4: return 4;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/sr_cfg_regs.sv
module sr_cfg_regs import sr_pkg::*; #(
  parameter int REG_W = 8,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] div_q,
  output logic [REG_W-1:0] mul_q,
  output logic [REG_W-1:0] code_q,
  output logic             cfg_wr
);
  logic hit_div, hit_mul, hit_code;

  assign hit_div  = wr_en && (wr_addr == AW'(SR_ADDR_DIV));
  assign hit_mul  = wr_en && (wr_addr == AW'(SR_ADDR_MUL));
  assign hit_code = wr_en && (wr_addr == AW'(SR_ADDR_CODE));
  // the constant offset SR_ADDR_CONST is accepted and discarded
  assign cfg_wr   = hit_div || hit_mul || hit_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= REG_W'(SR_DEF_DIV);
      mul_q  <= REG_W'(SR_DEF_MUL);
      code_q <= REG_W'(SR_DEF_CODE);
    end else begin
      if (hit_div)  div_q  <= wr_data;
      if (hit_mul)  mul_q  <= wr_data;
      if (hit_code) code_q <= wr_data;
    end
  end

  // R4: a write outside the three rate offsets leaves every field unchanged
  p_ignored_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !cfg_wr) |=> ($stable(div_q) && $stable(mul_q) && $stable(code_q)));
endmodule

// File: rtl/sr_base_decode.sv
module sr_base_decode import sr_pkg::*; #(
  parameter int CODE_W        = 8,
  parameter int TOP_BASE_HALF = 20_000_000,
  parameter int BASE_W        = $clog2(TOP_BASE_HALF + 1)
) (
  input  logic [CODE_W-1:0] code,
  output logic [BASE_W-1:0] base,
  output logic              valid
);
  localparam int LOW_W = 4;
  localparam int GRP_W = CODE_W - LOW_W;

  logic [BASE_W-1:0] decade [SR_NUM_GROUPS];

  // decade value of each group: top rate divided by successive powers of ten
  for (genvar g = 0; g < SR_NUM_GROUPS; g++) begin : g_decade
    assign decade[g] = BASE_W'(TOP_BASE_HALF / (10 ** g));
  end

  logic [GRP_W-1:0] grp;
  logic [LOW_W-1:0] step;
  int               grp_i;
  int               lim;

  assign grp  = code[CODE_W-1:LOW_W];
  assign step = code[LOW_W-1:0];

  always_comb begin
    grp_i = int'(grp);
    lim   = sr_group_limit(grp_i);
    valid = 1'b0;
    base  = '0;
    if (grp_i < SR_NUM_GROUPS && lim >= 0 && int'(step) <= lim) begin
      valid = 1'b1;
      base  = decade[grp_i] >> step;
    end
  end

  // R2: every listed code yields a non-zero increment
  always_comb begin
    if (valid) begin
      p_base_nonzero_r2: assert (base != '0);
    end
  end
endmodule

// File: rtl/sr_phase_accum.sv
module sr_phase_accum #(
  parameter int    REG_W    = 8,
  parameter int    BASE_W   = 25,
  parameter longint REF_HALF = 200_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              code_ok,
  input  logic [BASE_W-1:0] base,
  input  logic [REG_W-1:0]  mul,
  input  logic [REG_W-1:0]  div,
  output logic              strobe_o,
  output logic              unsup_o
);
  localparam int REF_W = $clog2(REF_HALF + 1);
  localparam int INC_W = BASE_W + REG_W;
  localparam int THR_W = REG_W + REF_W;
  localparam int ACC_W = ((INC_W > THR_W) ? INC_W : THR_W) + 1;

  logic [ACC_W-1:0] inc, thr, sum, acc_q;
  logic             bad;

  assign inc = ACC_W'(base) * ACC_W'(mul);
  assign thr = ACC_W'(div) * ACC_W'(REF_HALF);
  assign sum = acc_q + inc;
  assign bad = !code_ok || (div == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      strobe_o <= 1'b0;
      unsup_o  <= 1'b0;
    end else begin
      unsup_o <= bad;
      if (clr || bad) begin
        acc_q    <= '0;
        strobe_o <= 1'b0;
      end else if (inc >= thr) begin
        acc_q    <= '0;
        strobe_o <= 1'b1;
      end else if (sum >= thr) begin
        acc_q    <= sum - thr;
        strobe_o <= 1'b1;
      end else begin
        acc_q    <= sum;
        strobe_o <= 1'b0;
      end
    end
  end

  // R3: the residue stays below one full period on a valid setting
  p_acc_bound_r3: assert property (@(posedge clk) disable iff (rst)
    !bad |-> (acc_q < thr));
  // R5: a rate write restarts the phase from zero with no strobe
  p_clear_on_write_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_q == '0 && !strobe_o));
  // R6 and R7: an unsupported setting silences the strobe
  p_silent_bad_r6: assert property (@(posedge clk) disable iff (rst)
    bad |=> !strobe_o);
  // R6 and R7: an unsupported setting raises the flag
  p_flag_bad_r7: assert property (@(posedge clk) disable iff (rst)
    bad |=> unsup_o);
  // R8: at or above the reference rate every cycle strobes
  p_full_rate_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr && !bad && inc >= thr) |=> strobe_o);
endmodule

// File: rtl/sample_rate_gen.sv
module sample_rate_gen #(
  parameter int REG_W         = 8,
  parameter int AW            = 8,
  parameter int REF_HZ        = 100_000_000,
  parameter int TOP_BASE_HALF = 20_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic             strobe_o,
  output logic             unsup_o
);
  localparam longint REF_HALF = 2 * longint'(REF_HZ);
  localparam int     BASE_W   = $clog2(TOP_BASE_HALF + 1);

  logic [REG_W-1:0]  div_q, mul_q, code_q;
  logic              cfg_wr;
  logic [BASE_W-1:0] base;
  logic              code_ok;

  sr_cfg_regs #(.REG_W(REG_W), .AW(AW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .div_q   (div_q),
    .mul_q   (mul_q),
    .code_q  (code_q),
    .cfg_wr  (cfg_wr)
  );

  sr_base_decode #(.CODE_W(REG_W), .TOP_BASE_HALF(TOP_BASE_HALF), .BASE_W(BASE_W)) u_dec (
    .code  (code_q),
    .base  (base),
    .valid (code_ok)
  );

  sr_phase_accum #(.REG_W(REG_W), .BASE_W(BASE_W), .REF_HALF(REF_HALF)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .clr      (cfg_wr),
    .code_ok  (code_ok),
    .base     (base),
    .mul      (mul_q),
    .div      (div_q),
    .strobe_o (strobe_o),
    .unsup_o  (unsup_o)
  );
endmodule

// File: tb/tb_sample_rate_gen.sv
`timescale 1ns/1ps
module tb_sample_rate_gen;
  localparam int     REF_HZ   = 4_000_000;
  localparam longint REF_HALF = 2 * longint'(REF_HZ);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       strobe_o, unsup_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  sample_rate_gen #(.REF_HZ(REF_HZ)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .strobe_o(strobe_o), .unsup_o(unsup_o)
  );

  always #2 clk = ~clk;

  // R2 table in half-hertz units, 0 for an undefined code
  function automatic longint base_half(input int c);
    case (c)
      0: return 20_000_000;  1: return 10_000_000;  2: return 5_000_000;
      16: return 2_000_000; 17: return 1_000_000;
      32: return 200_000;   33: return 100_000;
      48: return 20_000;    49: return 10_000;    50: return 5_000;
      64: return 2_000;     65: return 1_000;     66: return 500;
      67: return 250;       68: return 125;
      default: return 0;
    endcase
  endfunction

  function automatic int code_of(input int i);
    int tbl [15] = '{0, 1, 2, 16, 17, 32, 33, 48, 49, 50, 64, 65, 66, 67, 68};
    return tbl[i];
  endfunction

  // R3 and R8 expected strobe count over n cycles from an empty accumulator
  function automatic longint exp_count(input int c, input int m, input int d, input int n);
    longint b, inc, thr;
    b = base_half(c);
    if (b == 0 || d == 0) return 0;
    inc = b * m;
    thr = longint'(d) * REF_HALF;
    if (inc >= thr) return n;
    return (longint'(n) * inc) / thr;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic configure(input int d, input int m, input int c);
    wr('h30, d);
    wr('h31, m);
    wr('h34, c);
  endtask

  // counts strobes over n cycles; optionally injects one write so that it is captured
  // on edge w+1 of the window
  task automatic window(input int n, input int w, input int a, input int d,
                        output int cnt, output int first, output bit flag1);
    cnt = 0; first = 0; flag1 = 0;
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      if (strobe_o) begin
        cnt++;
        if (first == 0) first = j;
      end
      if (j == 1) flag1 = unsup_o;
      if (w != 0 && j == w) begin
        wr_en = 1'b1; wr_addr = 8'(a); wr_data = 8'(d);
      end else begin
        wr_en = 1'b0;
      end
    end
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int cnt, first, seed_v;
    bit fl;
    seed_v = $urandom(32'd20240611);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 strobe in reset", strobe_o, 0);
    check("R1 flag in reset", unsup_o, 0);
    rst = 1'b0;

    // R1: defaults give 1 MHz = one strobe every 4 reference cycles
    window(40, 0, 0, 0, cnt, first, fl);
    check("R1 default count", cnt, 10);
    check("R1 default first strobe", first, 4);
    check("R1 default flag", fl, 0);

    // R4: constant register and unmapped addresses leave the train undisturbed
    configure(5, 5, 16);
    window(40, 5, 'h32, 2, cnt, first, fl);
    check("R4 const write ignored", cnt, 10);
    configure(5, 5, 16);
    window(40, 5, 'h33, 9, cnt, first, fl);
    check("R4 unmapped 0x33 ignored", cnt, 10);
    configure(5, 5, 16);
    window(40, 7, 'h40, 0, cnt, first, fl);
    check("R4 unmapped 0x40 ignored", cnt, 10);

    // R5: rewriting the multiplier mid-train clears the phase (strobes at 4, then 10..38)
    configure(5, 5, 16);
    window(40, 5, 'h31, 5, cnt, first, fl);
    check("R5 clear on rate write", cnt, 9);
    configure(5, 5, 16);
    window(40, 0, 0, 0, cnt, first, fl);
    check("R5 first strobe after write", first, 4);

    // R8: above and exactly at the reference rate
    configure(1, 1, 0);
    window(50, 0, 0, 0, cnt, first, fl);
    check("R8 above reference", cnt, 50);
    configure(1, 4, 16);
    window(50, 0, 0, 0, cnt, first, fl);
    check("R8 equal to reference", cnt, 50);
    check("R8 first strobe", first, 1);

    // R6: zero divisor
    configure(0, 5, 16);
    window(60, 0, 0, 0, cnt, first, fl);
    check("R6 div zero flag", fl, 1);
    check("R6 div zero silent", cnt, 0);

    // R7: undefined codes, then recovery
    for (int k = 0; k < 4; k++) begin
      int bad_codes [4] = '{3, 18, 69, 255};
      configure(5, 5, bad_codes[k]);
      window(60, 0, 0, 0, cnt, first, fl);
      check($sformatf("R7 code %0d flag", bad_codes[k]), fl, 1);
      check($sformatf("R7 code %0d silent", bad_codes[k]), cnt, 0);
    end
    configure(5, 5, 16);
    window(8, 0, 0, 0, cnt, first, fl);
    check("R7 flag cleared on recovery", fl, 0);

    // R2: every table entry with a multiplier/divisor pair chosen to keep the ratio measurable
    for (int i = 0; i < 15; i++) begin
      int c, m, d;
      longint b, mm;
      c = code_of(i);
      b = base_half(c);
      d = (b >= REF_HALF / 2) ? 255 : 1;
      mm = (2 * REF_HALF * d) / (5 * b);
      m = (mm < 1) ? 1 : ((mm > 255) ? 255 : int'(mm));
      configure(d, m, c);
      window(2000, 0, 0, 0, cnt, first, fl);
      check($sformatf("R2 code %0d count", c), cnt, exp_count(c, m, d, 2000));
      check($sformatf("R2 code %0d flag", c), fl, 0);
    end

    // R3: constrained random settings, occasionally unsupported
    for (int t = 0; t < 25; t++) begin
      int c, m, d;
      c = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 255)) : code_of($urandom_range(0, 14));
      m = $urandom_range(1, 255);
      d = ($urandom_range(0, 11) == 0) ? 0 : int'($urandom_range(1, 255));
      configure(d, m, c);
      window(1200, 0, 0, 0, cnt, first, fl);
      check($sformatf("R3 rand c=%0d m=%0d d=%0d count", c, m, d), cnt, exp_count(c, m, d, 1200));
      check($sformatf("R3 rand c=%0d d=%0d flag", c, d), fl,
            (base_half(c) == 0 || d == 0) ? 1 : 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule